// File: doc/BRIEF.md
# Memory-to-Memory Block Copy Engine

This block copies a run of words from one on-chip memory to another without CPU involvement. Software prepares it through two memory-mapped registers. The address register holds the memory-side base address. The control word holds the word count, a two-bit channel tag, a direction bit and a go bit, and it reports whether the engine is idle and whether the last copy has finished.

Once started, the engine sends read addresses to a source memory controller. The path to that controller goes through an arbiter, which grants or withholds each address with an acknowledge. The source controller returns data many cycles later, in order. There may be empty cycles between returned words. Each returned word is written to the destination port in the next cycle, with no back-pressure on that port.

The direction bit decides which side the programmed base address applies to. The other side counts up from address zero.

Top module: `blkCopyDma`

## Requirements
- R1: After reset, `rdReady` and `wrValid` are low, `xferChan` is 0, the control word reads 13'h0800 (only the idle bit, bit 11, is set) and the address register reads 0.
- R2: Register offset 3'h0 is the control word and offset 3'h4 is the address register (bits [12:0]); any other offset reads 0. Control word fields: count [6:0], channel [8:7], direction [9], go/busy [10], idle [11], finished [12]. Bits [12:11] ignore writes.
- R3: Writing the control word with bit 10 set while idle starts a copy of nonzero count. In the next cycle the engine reads busy: idle is 0, finished is 0, bit 10 is 1 and `rdReady` is 1. Count, channel and direction are latched at that write.
- R4: While busy, writes to either register are ignored. The copy keeps its count, channel and direction, and the address register keeps its value.
- R5: `rdReady` stays high until exactly count addresses have been granted. `rdAddr` advances by one only in a cycle where `rdReady` and `rdAck` are both high, and is held otherwise.
- R6: With direction 0, read address i is base+i and write address i is i. With direction 1, read address i is i and write address i is base+i. All addresses wrap modulo 2^13.
- R7: Each cycle with `rdValid` high during a copy produces exactly one write in the following cycle. That write has `wrValid` high and `wrData` equal to the returned word. Cycles with `rdValid` low produce no write.
- R8: The finished bit and the idle bit are set in the same cycle as the last write. Bit 10 then reads 0. The finished bit stays set until the next accepted start.
- R9: A start with count 0 gives idle=1 and finished=1 in the next cycle, and `rdReady` never rises.
- R10: The latched channel is driven on `xferChan` and reads back in bits [8:7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regOff | input | 3 | Register byte offset |
| regWdata | input | 13 | Register write data |
| regRdata | output | 13 | Register read data (combinational) |
| rdAddr | output | 13 | Read address to source controller |
| rdReady | output | 1 | Read request pending |
| rdAck | input | 1 | Arbiter grant of the current read address |
| rdValid | input | 1 | Returned read data valid |
| rdData | input | 32 | Returned read data |
| wrAddr | output | 13 | Destination write address |
| wrValid | output | 1 | Destination write strobe |
| wrData | output | 32 | Destination write data |
| xferChan | output | 2 | Latched channel tag |

## Verification
Register writes take effect at the next edge, so the busy state of R3 and the immediate finish of R9 are read back one cycle after the write strobe. A granted address leaves the port at the edge that samples the grant, so the bench records `rdAddr` in the same half-cycle in which it raises `rdAck`. Each write appears one cycle after its `rdValid` beat; the bench compares it against a bench-side model of the address order and the data pattern. The finished bit is checked in the very cycle the last write appears, by polling on falling edges after the responder has logged that cycle's write.

// File: rtl/dmaPkg.sv
package dmaPkg;
  localparam int CFG_W    = 13;
  localparam int LEN_W    = 7;
  localparam int CHAN_W   = 2;
  localparam int LEN_LSB  = 0;
  localparam int CHAN_LSB = 7;
  localparam int TYPE_BIT = 9;
  localparam int GO_BIT   = 10;
  localparam int IDLE_BIT = 11;
  localparam int DONE_BIT = 12;

  // strobes from control to datapath
  typedef struct packed {
    logic addrLoad;  // capture new base address
    logic xferLoad;  // a copy is starting
    logic dirBack;   // direction of the starting copy
    logic readAdv;   // read address granted this cycle
    logic beatTake;  // returned word accepted this cycle
  } dmaStrobeT;
endpackage

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaPkg::*;
#(
  parameter int REG_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regOff,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              rdAck,
  input  logic              rdValid,
  output logic              rdReady,
  output dmaStrobeT         strb,
  output logic [CFG_W-1:0]  cfgWord,
  output logic [CHAN_W-1:0] xferChan
);
  typedef enum logic {ST_IDLE, ST_RUN} stateT;

  stateT             state;
  logic              doneReg;
  logic              typeReg;
  logic [LEN_W-1:0]  lenReg;
  logic [CHAN_W-1:0] chanReg;
  logic [LEN_W-1:0]  issueCnt;
  logic [LEN_W-1:0]  beatCnt;

  logic             cfgWr;
  logic             addrWr;
  logic             isIdle;
  logic             startReq;
  logic [LEN_W-1:0] newLen;
  logic             lastBeat;
  logic             unusedRoBits;

  assign unusedRoBits = ^regWdata[DONE_BIT:IDLE_BIT];

  always_comb begin
    cfgWr    = regWrEn && (regOff == 3'h0);
    addrWr   = regWrEn && (regOff == 3'h4);
    isIdle   = (state == ST_IDLE);
    startReq = cfgWr && regWdata[GO_BIT] && isIdle;
    newLen   = regWdata[LEN_LSB +: LEN_W];
    rdReady  = (state == ST_RUN) && (issueCnt != lenReg);
    lastBeat = (state == ST_RUN) && rdValid && (beatCnt == lenReg - LEN_W'(1));
  end

  always_comb begin
    strb.addrLoad = addrWr && isIdle;
    strb.xferLoad = startReq;
    strb.dirBack  = regWdata[TYPE_BIT];
    strb.readAdv  = rdReady && rdAck;
    strb.beatTake = (state == ST_RUN) && rdValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      doneReg  <= 1'b0;
      typeReg  <= 1'b0;
      lenReg   <= '0;
      chanReg  <= '0;
      issueCnt <= '0;
      beatCnt  <= '0;
    end else if (startReq) begin
      lenReg   <= newLen;
      chanReg  <= regWdata[CHAN_LSB +: CHAN_W];
      typeReg  <= regWdata[TYPE_BIT];
      issueCnt <= '0;
      beatCnt  <= '0;
      if (newLen == '0) begin
        doneReg <= 1'b1;
      end else begin
        doneReg <= 1'b0;
        state   <= ST_RUN;
      end
    end else if (state == ST_RUN) begin
      if (strb.readAdv)  issueCnt <= issueCnt + LEN_W'(1);
      if (strb.beatTake) beatCnt  <= beatCnt + LEN_W'(1);
      if (lastBeat) begin
        state   <= ST_IDLE;
        doneReg <= 1'b1;
      end
    end
  end

  assign cfgWord  = {doneReg, isIdle, !isIdle, typeReg, chanReg, lenReg};
  assign xferChan = chanReg;

  // R5: never more grants than the programmed count
  a_r5_issue_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (issueCnt <= lenReg));
  // R4: parameters frozen while a copy runs
  a_r4_busy_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RUN) && $past(state == ST_RUN)) |->
      ($stable(lenReg) && $stable(chanReg) && $stable(typeReg)));
  // R8: finished only when idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |-> (state == ST_IDLE));
  // R9: zero count finishes at once
  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && (newLen == '0)) |=> (doneReg && (state == ST_IDLE)));
  // R5: no request while idle
  a_r5_ready_busy: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |-> !isIdle);
endmodule

// File: rtl/dmaPath.sv
module dmaPath
  import dmaPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobeT         strb,
  input  logic [ADDR_W-1:0] newBase,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrValid
);
  logic [ADDR_W-1:0] rdPtr;
  logic [ADDR_W-1:0] wrPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
    end else if (strb.addrLoad) begin
      baseAddr <= newBase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else if (strb.xferLoad) begin
      rdPtr <= strb.dirBack ? '0 : baseAddr;
      wrPtr <= strb.dirBack ? baseAddr : '0;
    end else begin
      if (strb.readAdv)  rdPtr <= rdPtr + ADDR_W'(1);
      if (strb.beatTake) wrPtr <= wrPtr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrValid <= strb.beatTake;
      if (strb.beatTake) begin
        wrAddr <= wrPtr;
        wrData <= rdData;
      end
    end
  end

  assign rdAddr = rdPtr;

  // R6: consecutive writes go to consecutive addresses
  a_r6_write_contig: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && $past(wrValid)) |-> (wrAddr == $past(wrAddr) + ADDR_W'(1)));
endmodule

// File: rtl/blkCopyDma.sv
module blkCopyDma
  import dmaPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32,
  localparam int REG_W = (ADDR_W > CFG_W) ? ADDR_W : CFG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regOff,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdReady,
  input  logic              rdAck,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              wrValid,
  output logic [DATA_W-1:0] wrData,
  output logic [CHAN_W-1:0] xferChan
);
  dmaStrobeT         strb;
  logic [CFG_W-1:0]  cfgWord;
  logic [ADDR_W-1:0] baseAddr;

  dmaCtrl #(.REG_W(REG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regOff   (regOff),
    .regWdata (regWdata),
    .rdAck    (rdAck),
    .rdValid  (rdValid),
    .rdReady  (rdReady),
    .strb     (strb),
    .cfgWord  (cfgWord),
    .xferChan (xferChan)
  );

  dmaPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .newBase  (regWdata[ADDR_W-1:0]),
    .rdData   (rdData),
    .baseAddr (baseAddr),
    .rdAddr   (rdAddr),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .wrValid  (wrValid)
  );

  always_comb begin
    case (regOff)
      3'h0:    regRdata = REG_W'(cfgWord);
      3'h4:    regRdata = REG_W'(baseAddr);
      default: regRdata = '0;
    endcase
  end

  // R5: an ungranted address is held
  a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rdReady && !rdAck) |=> $stable(rdAddr));
  // R7: a write only follows a returned word
  a_r7_write_follows: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> $past(rdValid));
endmodule

// File: tb/blkCopyDma_tb.sv
module blkCopyDma_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regOff = 3'h0;
  logic [12:0] regWdata = '0;
  logic [12:0] regRdata;
  logic [12:0] rdAddr;
  logic        rdReady;
  logic        rdAck = 1'b0;
  logic        rdValid = 1'b0;
  logic [31:0] rdData = '0;
  logic [12:0] wrAddr;
  logic        wrValid;
  logic [31:0] wrData;
  logic [1:0]  xferChan;

  blkCopyDma u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regOff(regOff),
    .regWdata(regWdata), .regRdata(regRdata), .rdAddr(rdAddr),
    .rdReady(rdReady), .rdAck(rdAck), .rdValid(rdValid), .rdData(rdData),
    .wrAddr(wrAddr), .wrValid(wrValid), .wrData(wrData), .xferChan(xferChan)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // current copy under test
  int          expBase, expLen, expTyp, ackPct, gapPct;
  logic [31:0] salt;
  bit          respOn = 1'b0;
  int          issued, wrIdx, head, tail;
  int          accAddr [0:127];
  int          readyAt [0:127];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int expRd(input int i);
    return (expTyp != 0) ? (i & 13'h1FFF) : ((expBase + i) & 13'h1FFF);
  endfunction

  function automatic int expWr(input int i);
    return (expTyp != 0) ? ((expBase + i) & 13'h1FFF) : (i & 13'h1FFF);
  endfunction

  function automatic logic [31:0] dataOf(input int a);
    return (32'(a) * 32'h9E3779B1) ^ salt;
  endfunction

  // memory-side model: arbiter grants, delayed returns with gaps, write checks
  always @(negedge clk) begin
    if (respOn) begin
      if (wrValid) begin
        if (wrIdx >= expLen) begin
          check(1'b0, "R7 extra write", wrIdx, expLen);
        end else begin
          check(wrAddr == 13'(expWr(wrIdx)), "R6 write address", int'(wrAddr), expWr(wrIdx));
          check(wrData == dataOf(expRd(wrIdx)), "R7 write data", int'(wrData), int'(dataOf(expRd(wrIdx))));
        end
        wrIdx++;
      end
      if (rdReady) begin
        if (issued >= expLen) check(1'b0, "R5 request beyond count", issued, expLen);
        if (int'($urandom % 100) < ackPct && issued < expLen) begin
          check(rdAddr == 13'(expRd(issued)), "R5 R6 read address", int'(rdAddr), expRd(issued));
          accAddr[tail] = expRd(issued);
          readyAt[tail] = cyc + 10 + int'($urandom % 4);
          tail++;
          issued++;
          rdAck = 1'b1;
        end else begin
          rdAck = ($urandom % 2) == 0 ? 1'b0 : 1'b0;
        end
      end else begin
        rdAck = 1'b0;
      end
      if (head < tail && readyAt[head] <= cyc && int'($urandom % 100) >= gapPct) begin
        rdValid = 1'b1;
        rdData  = dataOf(accAddr[head]);
        head++;
      end else begin
        rdValid = 1'b0;
        rdData  = $urandom;
      end
    end else begin
      rdAck   = 1'b0;
      rdValid = 1'b0;
    end
  end

  task automatic regWrite(input logic [2:0] off, input logic [12:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regOff = off; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0; regOff = 3'h0;
  endtask

  task automatic runXfer(input int base, input int len, input int typ, input int chan,
                         input int aPct, input int gPct, input bit poke);
    logic [12:0] cfg;
    int waitN;
    expBase = base & 13'h1FFF; expLen = len; expTyp = typ;
    ackPct = aPct; gapPct = gPct; salt = $urandom;
    issued = 0; wrIdx = 0; head = 0; tail = 0;
    regWrite(3'h4, 13'(base));
    cfg = 13'((1 << 10) | (typ << 9) | (chan << 7) | len);
    respOn = 1'b1;
    regWrite(3'h0, cfg);
    #1;
    if (len == 0) begin
      check(regRdata[12] && regRdata[11], "R9 immediate finish", int'(regRdata), 13'h1800);
      check(!rdReady, "R9 no request", int'(rdReady), 0);
    end else begin
      check(regRdata[12:10] == 3'b001, "R3 busy after start", int'(regRdata[12:10]), 1);
      check(rdReady, "R3 request raised", int'(rdReady), 1);
      check(xferChan == 2'(chan), "R10 channel output", int'(xferChan), chan);
    end
    if (poke && len > 0) begin
      regWrite(3'h4, ~13'(base));
      regWrite(3'h0, 13'((1 << 10) | ((1 - typ) << 9) | ((3 - chan) << 7) | 5));
    end
    waitN = 0;
    forever begin
      @(negedge clk); #1;
      regOff = 3'h0;
      #1;
      if (regRdata[11] || waitN > 6000) break;
      waitN++;
    end
    check(regRdata[11], "R8 copy ends", int'(regRdata[11]), 1);
    check(wrIdx == len, "R8 R4 write count at finish", wrIdx, len);
    if (len > 0) check(wrValid, "R8 finish with last write", int'(wrValid), 1);
    check(regRdata == 13'((1 << 12) | (1 << 11) | (typ << 9) | (chan << 7) | len),
          "R8 R10 R2 final control word", int'(regRdata),
          (1 << 12) | (1 << 11) | (typ << 9) | (chan << 7) | len);
    regOff = 3'h4; #1;
    check(regRdata == 13'(base), "R4 R2 address register", int'(regRdata), base & 13'h1FFF);
    regOff = 3'h0;
    repeat (4) @(negedge clk);
    #1;
    check(regRdata[12] && !rdReady, "R8 finished holds", int'(regRdata), 13'h1800);
    check(wrIdx == len, "R7 no late writes", wrIdx, len);
    respOn = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(!rdReady && !wrValid, "R1 idle outputs", int'({rdReady, wrValid}), 0);
    check(regRdata == 13'h0800, "R1 control word", int'(regRdata), 13'h0800);
    check(xferChan == 2'd0, "R1 channel", int'(xferChan), 0);
    regOff = 3'h4; #1;
    check(regRdata == 13'h0, "R1 address reg", int'(regRdata), 0);
    regOff = 3'h2; #1;
    check(regRdata == 13'h0, "R2 unused offset", int'(regRdata), 0);
    regOff = 3'h0;
    // R2 read-only status bits ignore writes
    regWrite(3'h0, 13'h1800);
    #1;
    check(regRdata == 13'h0800, "R2 status bits read-only", int'(regRdata), 13'h0800);
    // directed cases
    runXfer(13'h0040, 1, 0, 1, 100, 0, 1'b0);
    runXfer(13'h0123, 0, 1, 2, 100, 0, 1'b0);             // R9
    runXfer(13'h1FF0, 127, 1, 3, 100, 0, 1'b0);           // R6 wrap
    runXfer(13'h1FFA, 20, 0, 0, 40, 30, 1'b0);            // R6 wrap on read side
    runXfer(13'h0200, 30, 0, 2, 20, 60, 1'b1);            // R4 busy pokes
    // random mix
    for (int k = 0; k < 10; k++) begin
      runXfer(int'($urandom % 8192), 1 + int'($urandom % 60), int'($urandom % 2),
              int'($urandom % 4), 20 + int'($urandom % 81), int'($urandom % 50),
              ($urandom % 3) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule